// File: doc/BRIEF.md
# Graphics Aperture Configuration Register File

This block holds the configuration for a graphics memory window. A simple 32-bit register port reaches three registers by byte offset. The size control register selects 128 MB, 256 MB or 512 MB. The aperture base register stores address bits 31:27. The size setting decides which of those bits software may write, and the block holds the other bits at zero. The stolen-memory base register stores address bits 31:20 and a lock bit. Once software sets the lock, the register is frozen until the next reset.

The block also forms physical addresses. An offset enters on a valid/ready stream. The block adds it to the stolen-memory base and returns the 32-bit sum on a second valid/ready stream one cycle later. Back-pressure works as follows:
- The input is accepted whenever the output register is empty or is being drained in that same cycle.
- A result that is held because `phys_ready` is low keeps its value until it is taken.

Register reads are combinational from `reg_addr`. Register writes take effect at the clock edge at which `reg_wr` is sampled high.

Top module: `gfx_aperture_regs`

## Requirements
- R1: After reset, the size register reads 0x0002_0000 (size code 01), the aperture base reads 0, and the stolen-memory base reads 0.
- R2: At offset 0x60 the size code sits in bits 18:17, and every other bit reads 0. Codes are 00 for 128 MB, 01 for 256 MB and 11 for 512 MB. A write of code 10 is ignored, so the register keeps its previous code.
- R3: At offset 0x18 the aperture base stores bits 31:27, and bits 26:0 read 0. Bits 31:29 are always writable. Bit 28 is writable for codes 00 and 01 and is held at 0 for code 11. Bit 27 is writable only for code 00.
- R4: A size change clears, at the same clock edge, every aperture base bit that the new code holds at 0.
- R5: At offset 0x70, bits 31:20 hold the stolen-memory base, and bits 19:1 read 0.
- R6: Bit 0 at offset 0x70 is the lock bit. While it is 1, writes to offset 0x70 change neither the base nor the lock bit.
- R7: An offset accepted at a clock edge appears on `phys_addr` with `phys_valid` high after that edge. The value is {base,20'b0} plus the offset, modulo 2^32.
- R8: `off_ready` equals `!phys_valid || phys_ready`. While `phys_valid` is high and `phys_ready` is low, `phys_valid` and `phys_addr` stay unchanged.
- R9: Reads of any offset other than 0x18, 0x60 and 0x70 return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| off_valid | input | 1 | Offset stream valid |
| off_ready | output | 1 | Offset stream ready |
| off_data | input | 32 | Offset to add to the stolen base |
| phys_valid | output | 1 | Physical address valid |
| phys_ready | input | 1 | Downstream ready |
| phys_addr | output | 32 | Sum of the stolen base and the offset |

## Verification
The assertions check these properties on every cycle:
- The size code never holds the illegal value.
- Aperture base bits that the current size holds at zero stay zero.
- A set lock freezes the stolen-memory register.
- A held result stays stable, and an accepted offset produces a valid result on the next cycle.

Only the bench scenarios can show the values themselves:
- the exact masking applied to written data under each size;
- the clearing that happens when the size is shrunk;
- addition that wraps past bit 31;
- writes that are ignored at unmapped offsets, with the illegal code, and after the lock is set.

The bench shows these by comparing read data and the output stream against a behavioural model on every clock.

// File: rtl/gap_pkg.sv
package gap_pkg;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int AP_LSB = 27;
  localparam int AP_W = DW - AP_LSB;
  localparam int SB_LSB = 20;
  localparam int SB_W = DW - SB_LSB;
  localparam int SZ_LSB = 17;

  localparam logic [AW-1:0] OFS_APBASE = 8'h18;
  localparam logic [AW-1:0] OFS_SIZE   = 8'h60;
  localparam logic [AW-1:0] OFS_STOLEN = 8'h70;

  typedef enum logic [1:0] {
    SZ_128 = 2'b00,
    SZ_256 = 2'b01,
    SZ_BAD = 2'b10,
    SZ_512 = 2'b11
  } size_code_t;

  // Writable aperture base bits (31:27) for a given size code.
  function automatic logic [AP_W-1:0] ap_mask(input size_code_t s);
    logic [AP_W-1:0] m;
    m = '1;
    case (s)
      SZ_128:  m = '1;
      SZ_256:  m[0] = 1'b0;
      default: m[1:0] = 2'b00;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/gap_size_reg.sv
module gap_size_reg
  import gap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  output size_code_t size_q,
  output size_code_t size_nxt
);
  always_comb begin
    size_nxt = size_q;
    if (wr_en && (wr_code != SZ_BAD)) size_nxt = size_code_t'(wr_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) size_q <= SZ_256;
    else        size_q <= size_nxt;
  end

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    size_q != SZ_BAD); // R2
  AST_BAD_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == SZ_BAD) |=> $stable(size_q)); // R2
endmodule

// File: rtl/gap_apbase_reg.sv
module gap_apbase_reg
  import gap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AP_W-1:0] wr_bits,
  input  size_code_t      size_nxt,
  output logic [AP_W-1:0] ap_q
);
  logic [AP_W-1:0] ap_d;

  // Mask with the size that takes effect at this edge, so a shrink clears at once.
  always_comb begin
    ap_d = wr_en ? wr_bits : ap_q;
    ap_d = ap_d & ap_mask(size_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ap_q <= '0;
    else        ap_q <= ap_d;
  end
endmodule

// File: rtl/gap_stolen_reg.sv
module gap_stolen_reg
  import gap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [SB_W-1:0] base_q,
  output logic            lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lock_q <= 1'b0;
    end else if (wr_en && !lock_q) begin
      base_q <= wr_data[DW-1:SB_LSB];
      lock_q <= wr_data[0];
    end
  end

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(base_q))); // R6
endmodule

// File: rtl/gap_addr_pipe.sv
module gap_addr_pipe
  import gap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SB_W-1:0] base,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_off,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_addr
);
  logic [DW-1:0] sum;

  assign sum      = {base, {SB_LSB{1'b0}}} + in_off;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= sum;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R7
endmodule

// File: rtl/gfx_aperture_regs.sv
module gfx_aperture_regs
  import gap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          off_valid,
  output logic          off_ready,
  input  logic [DW-1:0] off_data,
  output logic          phys_valid,
  input  logic          phys_ready,
  output logic [DW-1:0] phys_addr
);
  size_code_t      size_q, size_nxt;
  logic [AP_W-1:0] ap_q;
  logic [SB_W-1:0] sb_q;
  logic            lock_q;
  logic            wr_size, wr_ap, wr_sb;

  assign wr_size = reg_wr && (reg_addr == OFS_SIZE);
  assign wr_ap   = reg_wr && (reg_addr == OFS_APBASE);
  assign wr_sb   = reg_wr && (reg_addr == OFS_STOLEN);

  gap_size_reg u_size (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_size),
    .wr_code(reg_wdata[SZ_LSB+1:SZ_LSB]),
    .size_q(size_q), .size_nxt(size_nxt)
  );

  gap_apbase_reg u_ap (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ap),
    .wr_bits(reg_wdata[DW-1:AP_LSB]), .size_nxt(size_nxt), .ap_q(ap_q)
  );

  gap_stolen_reg u_sb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sb),
    .wr_data(reg_wdata), .base_q(sb_q), .lock_q(lock_q)
  );

  gap_addr_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .base(sb_q),
    .in_valid(off_valid), .in_ready(off_ready), .in_off(off_data),
    .out_valid(phys_valid), .out_ready(phys_ready), .out_addr(phys_addr)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_SIZE:   reg_rdata[SZ_LSB+1:SZ_LSB] = size_q;
      OFS_APBASE: reg_rdata[DW-1:AP_LSB]     = ap_q;
      OFS_STOLEN: reg_rdata = {sb_q, {(SB_LSB-1){1'b0}}, lock_q};
      default:    reg_rdata = '0;
    endcase
  end

  AST_AP_FORCED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_q & ~ap_mask(size_q)) == '0); // R4
  AST_SB_UNCHANGED_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sb |=> ($stable(sb_q) && $stable(lock_q))); // R9
endmodule

// File: tb/gfx_aperture_regs_test.sv
module gfx_aperture_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        off_valid = 1'b0;
  logic        off_ready;
  logic [31:0] off_data = '0;
  logic        phys_valid;
  logic        phys_ready = 1'b1;
  logic [31:0] phys_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural model state
  int          m_size = 1;
  logic [4:0]  m_ap = '0;
  logic [11:0] m_base = '0;
  logic        m_lock = 1'b0;
  logic        m_v = 1'b0;
  logic [31:0] m_addr = '0;

  always #2.5 clk = ~clk;

  gfx_aperture_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .off_valid(off_valid),
    .off_ready(off_ready), .off_data(off_data), .phys_valid(phys_valid),
    .phys_ready(phys_ready), .phys_addr(phys_addr)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h60:   return 32'(m_size) << 17;
      8'h18:   return {m_ap, 27'b0};
      8'h70:   return {m_base, 19'b0, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  // One clock: model advances alongside the design, then everything is compared.
  task automatic step(input string tag);
    int          n_size;
    logic [4:0]  n_ap;
    logic [11:0] n_base;
    logic        n_lock, n_v;
    logic [31:0] n_addr;
    #1;
    chk({tag, " R8 ready"}, {31'b0, off_ready}, {31'b0, (!m_v || phys_ready)});
    n_size = m_size; n_ap = m_ap; n_base = m_base; n_lock = m_lock;
    n_v = m_v; n_addr = m_addr;
    if (reg_wr && reg_addr == 8'h60 && reg_wdata[18:17] != 2'b10)
      n_size = int'(reg_wdata[18:17]);
    if (reg_wr && reg_addr == 8'h18) n_ap = reg_wdata[31:27];
    if (n_size == 1) n_ap[0] = 1'b0;
    if (n_size == 3) n_ap[1:0] = 2'b00;
    if (reg_wr && reg_addr == 8'h70 && !m_lock) begin
      n_base = reg_wdata[31:20]; n_lock = reg_wdata[0];
    end
    if (!m_v || phys_ready) begin
      n_v = off_valid;
      if (off_valid) n_addr = {m_base, 20'b0} + off_data;
    end
    @(posedge clk);
    @(negedge clk);
    m_size = n_size; m_ap = n_ap; m_base = n_base; m_lock = n_lock;
    m_v = n_v; m_addr = n_addr;
    chk({tag, " rdata"}, reg_rdata, m_read(reg_addr));
    chk({tag, " R7 valid"}, {31'b0, phys_valid}, {31'b0, m_v});
    if (m_v) chk({tag, " R7 addr"}, phys_addr, m_addr);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    step(tag);
    reg_wr = 1'b0;
    step({tag, " readback"});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    reg_addr = a;
    step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(8'h60, "R1 size");
    chk("R1 size abs", reg_rdata, 32'h0002_0000);
    rd(8'h18, "R1 apbase");
    rd(8'h70, "R1 stolen");
    // R2 / R3 masking per size
    wr(8'h60, 32'h0000_0000, "R2 size128");
    wr(8'h18, 32'hFFFF_FFFF, "R3 ap128");
    chk("R3 abs", reg_rdata, 32'hF800_0000);
    // R4 shrink clears forced bits
    wr(8'h60, 32'h0002_0000, "R4 size256");
    rd(8'h18, "R4 ap256");
    chk("R4 abs256", reg_rdata, 32'hF000_0000);
    wr(8'h18, 32'hFFFF_FFFF, "R3 ap256");
    wr(8'h60, 32'hFFFF_FFFF, "R4 size512");
    rd(8'h18, "R4 ap512");
    chk("R4 abs512", reg_rdata, 32'hE000_0000);
    // R2 illegal code ignored
    wr(8'h60, 32'h0004_0000, "R2 illegal");
    chk("R2 abs", reg_rdata, 32'h0006_0000);
    // R9 unmapped
    wr(8'h44, 32'hFFFF_FFFF, "R9 unmapped");
    chk("R9 abs", reg_rdata, 32'h0);
    rd(8'h70, "R9 stolen untouched");
    rd(8'h60, "R9 size untouched");
    // R5 stolen base
    wr(8'h70, 32'hABCD_EFFE, "R5 stolen");
    chk("R5 abs", reg_rdata, 32'hABC0_0000);
    // R7 address sums, including wrap
    reg_addr = 8'h70;
    off_valid = 1'b1; off_data = 32'h0012_3456; step("R7 sum");
    off_data = 32'h6000_0000; step("R7 wrap");
    chk("R7 wrap abs", phys_addr, 32'h0BC0_0000);
    off_valid = 1'b0; step("R7 idle");
    // R8 back-pressure
    phys_ready = 1'b0;
    off_valid = 1'b1; off_data = 32'h0000_0100; step("R8 load");
    off_data = 32'h0000_0200; step("R8 stall1");
    step("R8 stall2");
    chk("R8 held abs", phys_addr, 32'hABC0_0100);
    phys_ready = 1'b1; step("R8 drain");
    off_valid = 1'b0; step("R8 last");
    // R6 lock
    wr(8'h70, 32'h1230_0001, "R6 set lock");
    chk("R6 abs", reg_rdata, 32'h1230_0001);
    wr(8'h70, 32'h0000_0000, "R6 locked write");
    chk("R6 held abs", reg_rdata, 32'h1230_0001);
    off_valid = 1'b1; off_data = 32'h0000_0001; step("R6 base used");
    off_valid = 1'b0; step("R6 idle");
    report();
  end
endmodule